// File: doc/BRIEF.md
# Host-to-Local Address Window Translator

This block sits between a host-side firmware address stream and a local memory fabric. It holds one remappable window. Each host request carries a 32-bit address. The block decides whether that address lies inside the window. If it does, the block forwards an equivalent local address. If it does not, or while the window is switched off, it reports no-hit.

Software programs the window through three 32-bit registers: a control register holding two enable bits, a base register and a mask register. The base register holds the upper 16 bits of the local target address in its top half and the upper 16 bits of the host-side window address in its bottom half. The mask register also splits into two halves. Ones in its top half mark upper request bits that are replaced by base bits. Ones in its bottom half mark upper request bits that pass straight through. A window of size S (a power of two, at least 64 KiB) is therefore programmed as follows:

- top half of the mask: the upper 16 bits of ~(S-1);
- bottom half of the mask: (S>>16)-1.

Windows are aligned to their own size, on both the host side and the local side.

The request and response sides each use a valid/ready handshake. A response appears one cycle after its request is accepted.

Top module: `hostwin_xlate`

## Requirements
- R1: After reset, all three registers read zero, rsp_valid is low and req_ready is high.
- R2: The control register is at offset 0x0, the base register at 0x8 and the mask register at 0xC. Only control bits 8 and 10 are stored; the other control bits read zero. A write to any other offset is ignored, and reading any other offset returns zero.
- R3: Translation happens only when control bits 8 and 10 are both set. With either bit clear, every request returns rsp_hit low.
- R4: A request hits when bits [31:16] of its address equal the bottom half of the base register, ignoring the bit positions set in the bottom half of the mask.
- R5: On a hit, each local address bit in [31:16] is built as follows:
  - if the top mask half is set at that position, the bit comes from the base register's top half;
  - if the bottom mask half is set at that position, the bit comes from the request;
  - if neither is set, the bit is zero.
- R6: On a hit, local address bits [15:0] equal request bits [15:0].
- R7: On a miss, rsp_hit is low and rsp_addr is zero.
- R8: A register write takes effect on the next clock edge. A request accepted in the same cycle as the write is translated with the old register values.
- R9: A request accepted at a clock edge produces rsp_valid high after that same edge, which is one cycle of latency.
- R10: While rsp_valid is high and rsp_ready is low:
  - rsp_valid, rsp_hit and rsp_addr hold steady;
  - req_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Host-side address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_hit | output | 1 | Request fell inside the enabled window |
| rsp_addr | output | 32 | Translated local address, zero on a miss |

## Verification
The bench sweeps window sizes from 64 KiB to 512 KiB against several aligned local offsets. For each window it probes the first byte, the last byte, the bytes just outside either edge, and a far address. The expected result comes from plain range arithmetic rather than from mask logic.

Each probe targets a specific fault:
- an off-by-one in the keep/replace masks either misses the last byte or hits the byte past the end;
- mixing up which mask half is used scrambles the local offset;
- a design enabled by a single control bit hits when it should not;
- a write that bypasses the old register values translates the request that shares its cycle with the new values;
- a response stage that does not stall drops or overwrites a held response under backpressure.

// File: rtl/hostwin_pkg.sv
package hostwin_pkg;

    localparam int REG_W  = 32;
    localparam int HALF_W = REG_W / 2;
    localparam int OFFS_W = 4;

    localparam logic [OFFS_W-1:0] OFF_CTRL = 4'h0;
    localparam logic [OFFS_W-1:0] OFF_BASE = 4'h8;
    localparam logic [OFFS_W-1:0] OFF_MASK = 4'hC;

    localparam int EN_LO_BIT = 8;
    localparam int EN_HI_BIT = 10;

    localparam logic [REG_W-1:0] CTRL_KEEP =
        (REG_W'(1) << EN_LO_BIT) | (REG_W'(1) << EN_HI_BIT);

    typedef struct packed {
        logic [HALF_W-1:0] tgt_hi;
        logic [HALF_W-1:0] host_hi;
    } base_t;

    typedef struct packed {
        logic [HALF_W-1:0] repl;
        logic [HALF_W-1:0] keep;
    } mask_t;

    typedef struct packed {
        logic             hit;
        logic [REG_W-1:0] addr;
    } xlate_t;

    function automatic logic ctrl_enabled(input logic [REG_W-1:0] c);
        return c[EN_LO_BIT] & c[EN_HI_BIT];
    endfunction

endpackage

// File: rtl/hostwin_regfile.sv
module hostwin_regfile
    import hostwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output base_t             base_q,
    output mask_t             mask_q,
    output logic              en_q
);

    logic [REG_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            base_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            case (addr)
                OFF_CTRL: ctrl_q <= wdata & CTRL_KEEP;
                OFF_BASE: base_q <= base_t'(wdata);
                OFF_MASK: mask_q <= mask_t'(wdata);
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            OFF_CTRL: rdata = ctrl_q;
            OFF_BASE: rdata = base_q;
            OFF_MASK: rdata = mask_q;
            default:  rdata = '0;
        endcase
    end

    assign en_q = ctrl_enabled(ctrl_q);

endmodule

// File: rtl/hostwin_match.sv
module hostwin_match
    import hostwin_pkg::*;
(
    input  logic [REG_W-1:0] req_addr,
    input  base_t            base,
    input  mask_t            mask,
    input  logic             en,
    output xlate_t           result
);

    logic [HALF_W-1:0] up;
    logic [HALF_W-1:0] differ;
    logic [HALF_W-1:0] mapped;

    assign up = req_addr[REG_W-1:HALF_W];

    for (genvar b = 0; b < HALF_W; b++) begin : g_bit
        assign differ[b] = (up[b] ^ base.host_hi[b]) & ~mask.keep[b];
        assign mapped[b] = (base.tgt_hi[b] & mask.repl[b]) | (up[b] & mask.keep[b]);
    end

    logic hit;
    assign hit = en & ~(|differ);

    always_comb begin
        result.hit  = hit;
        result.addr = hit ? {mapped, req_addr[HALF_W-1:0]} : '0;
    end

endmodule

// File: rtl/hostwin_stage.sv
module hostwin_stage
    import hostwin_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    output logic   in_ready,
    input  xlate_t in_data,
    output logic   out_valid,
    input  logic   out_ready,
    output xlate_t out_data
);

    assign in_ready = ~out_valid | out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end

endmodule

// File: rtl/hostwin_xlate.sv
module hostwin_xlate
    import hostwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [OFFS_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [REG_W-1:0]  req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_hit,
    output logic [REG_W-1:0]  rsp_addr
);

    base_t  base_q;
    mask_t  mask_q;
    logic   win_en;
    xlate_t comb_res;
    xlate_t held_res;

    hostwin_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .base_q (base_q),
        .mask_q (mask_q),
        .en_q   (win_en)
    );

    hostwin_match u_match (
        .req_addr (req_addr),
        .base     (base_q),
        .mask     (mask_q),
        .en       (win_en),
        .result   (comb_res)
    );

    hostwin_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_data   (comb_res),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_data  (held_res)
    );

    assign rsp_hit  = held_res.hit;
    assign rsp_addr = held_res.addr;

endmodule

// File: rtl/hostwin_xlate_chk.sv
module hostwin_xlate_chk
    import hostwin_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [REG_W-1:0] req_addr,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic             rsp_hit,
    input logic [REG_W-1:0] rsp_addr,
    input logic             win_en
);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid);

    p_disabled_miss_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !win_en) |=> !rsp_hit);

    p_low_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            (!rsp_hit || rsp_addr[HALF_W-1:0] == $past(req_addr[HALF_W-1:0])));

    p_miss_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> rsp_addr == '0);

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_hit) && $stable(rsp_addr)));

    p_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

bind hostwin_xlate hostwin_xlate_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_hit   (rsp_hit),
    .rsp_addr  (rsp_addr),
    .win_en    (win_en)
);

// File: tb/hostwin_xlate_tb_top.sv
`timescale 1ns/1ps
module hostwin_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic        rsp_hit;
    logic [31:0] rsp_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    hostwin_xlate dut_i (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic xact(input logic [31:0] a, output logic h, output logic [31:0] o,
                        output logic lat_ok);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        lat_ok = req_ready;
        @(negedge clk);
        req_valid = 1'b0;
        h = rsp_hit; o = rsp_addr;
        lat_ok = lat_ok & rsp_valid;
    endtask

    // Set up a window of the given size (R4, R5: standard mask programming)
    task automatic set_window(input logic [31:0] hb, input logic [31:0] tgt, input logic [31:0] sz);
        logic [31:0] nm;
        logic [15:0] keep;
        nm   = ~(sz - 32'd1);
        keep = 16'((sz >> 16) - 32'd1);
        wr_reg(4'h8, {tgt[31:16], hb[31:16]});
        wr_reg(4'hC, {nm[31:16], keep});
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d, o;
        logic h, lat;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 req_ready", {31'd0, req_ready}, 32'd1);
        rd_reg(4'h0, d); check("R1 ctrl", d, 32'h0);
        rd_reg(4'h8, d); check("R1 base", d, 32'h0);
        rd_reg(4'hC, d); check("R1 mask", d, 32'h0);

        // R2: offsets and stored control bits
        wr_reg(4'h0, 32'hFFFF_FFFF);
        rd_reg(4'h0, d); check("R2 ctrl bits", d, 32'h0000_0500);
        wr_reg(4'h4, 32'hDEAD_BEEF);
        rd_reg(4'h4, d); check("R2 unmapped offset", d, 32'h0);
        rd_reg(4'h8, d); check("R2 base untouched", d, 32'h0);
        rd_reg(4'hC, d); check("R2 mask untouched", d, 32'h0);
        wr_reg(4'h8, 32'h1234_5678);
        rd_reg(4'h8, d); check("R2 base readback", d, 32'h1234_5678);
        wr_reg(4'hC, 32'h9ABC_DEF0);
        rd_reg(4'hC, d); check("R2 mask readback", d, 32'h9ABC_DEF0);

        // R3: both enable bits required
        set_window(32'h0A00_0000, 32'h4000_0000, 32'h0001_0000);
        wr_reg(4'h0, 32'h0000_0100);
        xact(32'h0A00_0042, h, o, lat);
        check("R3 only bit8 hit", {31'd0, h}, 32'd0);
        check("R7 miss addr zero", o, 32'd0);
        wr_reg(4'h0, 32'h0000_0400);
        xact(32'h0A00_0042, h, o, lat);
        check("R3 only bit10 hit", {31'd0, h}, 32'd0);
        wr_reg(4'h0, 32'h0000_0500);
        xact(32'h0A00_0042, h, o, lat);
        check("R3 both bits hit", {31'd0, h}, 32'd1);
        check("R3 both bits addr", o, 32'h4000_0042);

        // R4 R5 R6 R7 R9: sweep window sizes, offsets and probe points
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 4; j++) begin
                logic [31:0] sz, hb, tgt;
                sz  = 32'h0001_0000 << k;
                hb  = 32'h0A00_0000 + (32'(j) << 20);
                tgt = 32'h4000_0000 + 32'(j) * sz;
                set_window(hb, tgt, sz);
                for (int p = 0; p < 6; p++) begin
                    logic [31:0] a, ea;
                    logic eh;
                    case (p)
                        0: a = hb;
                        1: a = hb + sz - 32'd1;
                        2: a = hb - 32'd1;
                        3: a = hb + sz;
                        4: a = hb + (sz >> 1) + 32'h1234;
                        default: a = hb ^ 32'h8000_0000;
                    endcase
                    eh = (a >= hb) && (a < hb + sz);
                    ea = eh ? tgt + (a - hb) : 32'd0;
                    xact(a, h, o, lat);
                    check("R4 hit decision", {31'd0, h}, {31'd0, eh});
                    check(eh ? "R5 R6 translated addr" : "R7 miss addr", o, ea);
                    check("R9 one-cycle latency", {31'd0, lat}, 32'd1);
                end
            end
        end

        // R8: write in same cycle as request uses old values
        set_window(32'h0A00_0000, 32'h4000_0000, 32'h0001_0000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h0;
        req_valid = 1'b1; req_addr = 32'h0A00_0005;
        @(negedge clk);
        reg_wr = 1'b0; req_valid = 1'b0;
        check("R8 same-cycle hit", {31'd0, rsp_hit}, 32'd1);
        check("R8 same-cycle addr", rsp_addr, 32'h4000_0005);
        xact(32'h0A00_0005, h, o, lat);
        check("R8 next request sees write", {31'd0, h}, 32'd0);
        wr_reg(4'h0, 32'h0000_0500);

        // R10: backpressure holds response and blocks requests
        @(negedge clk);
        rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h0A00_0077;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 3; c++) begin
            check("R10 held valid", {31'd0, rsp_valid}, 32'd1);
            check("R10 held addr", rsp_addr, 32'h4000_0077);
            check("R10 req_ready low", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R10 drained", {31'd0, rsp_valid}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule